// File: doc/BRIEF.md
# Geometry Command Port Bridge

This block connects the register-sampled I/O bus of an 8-bit processor to a graphics geometry engine. The processor writes a 16-bit geometry command as two bytes, one to a low-byte port and one to a high-byte port. Each port keeps its own data register and raises its own single-cycle write strobe. The strobe of the byte chosen as the commit byte also pushes the assembled word into the engine's 512-word command FIFO. The FIFO storage sits outside this block. The commit byte is chosen by a parameter, and software then writes that byte second.

A status port reports the FIFO almost-full flag, a frame-sync bit and two sticky error bits. Writes to the same port control the geometry section's reset, which holds the engine asleep until software releases it. Two further read ports return the write-pixel and copy-read-pixel collision counters. Every readable port raises its own read strobe, so the logic that owns a counter can clear and refresh it once the processor has read it. A stall monitor counts consecutive status reads that find the FIFO almost full. When the count reaches a limit, it sets a sticky fault bit, and the driver can then reset the engine.

Top module: `geo_io_bridge`

## Requirements
- R1: A write to port 0xF0 loads `geo_lo` and a write to port 0xF1 loads `geo_hi`. The loaded value appears on the cycle after the write qualifier. The other byte register is unchanged.
- R2: `geo_lo_stb` and `geo_hi_stb` are each high for exactly the one cycle after a write to their own port, and low in every other cycle, including after writes to other or unmapped ports.
- R3: With the default commit on the high byte, a high-byte write raises `cmd_push` for one cycle, together with `cmd_word` = {new high byte, current low byte}. A low-byte write pushes nothing.
- R4: When `fifo_full` is high at a commit write, `cmd_push` stays low and the sticky overflow bit (status bit 5) is set. That bit stays set until a status write with bit 5 = 1.
- R5: A status read (port 0xF2) returns bit 0 = `fifo_afull`, bit 1 = `frame_sync`, bit 5 = overflow, bit 6 = fault, bit 7 = geometry reset, and 0 in bits 2 to 4. The sticky bits are reported as they stood before the read.
- R6: A read of port 0xF2, 0xF3 (write-pixel counter) or 0xF4 (copy-read-pixel counter) updates `rd_data` on the next cycle and raises only that port's read strobe for one cycle. An unmapped read returns 0 and raises no strobe.
- R7: A status write sets `geo_reset` to data bit 7 and raises `ctl_wr_stb` for one cycle. `geo_reset` changes at no other time.
- R8: Each status read that sees almost-full increments a stall count, and a status read that does not see almost-full zeroes it. The read that brings the count to FAULT_LIMIT sets the sticky fault bit (status bit 6). A status write with bit 6 = 1 clears both the fault bit and the count.
- R9: During reset, all data registers, strobes, `cmd_push`, `rd_data` and the sticky bits are 0, and `geo_reset` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | One-cycle port-write qualifier |
| io_rd | input | 1 | One-cycle port-read qualifier |
| io_addr | input | 8 | Low byte of captured I/O address |
| io_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| geo_lo | output | 8 | Low-byte data register |
| geo_hi | output | 8 | High-byte data register |
| geo_lo_stb | output | 1 | Low-byte write strobe |
| geo_hi_stb | output | 1 | High-byte write strobe |
| cmd_word | output | 16 | Assembled command word |
| cmd_push | output | 1 | FIFO push strobe |
| fifo_full | input | 1 | FIFO full |
| fifo_afull | input | 1 | FIFO almost full (510 words) |
| frame_sync | input | 1 | Frame toggle or line strobe |
| wpix_cnt | input | 8 | Write-pixel collision counter |
| cpix_cnt | input | 8 | Copy-read-pixel collision counter |
| stat_rd_stb | output | 1 | Status read strobe |
| wpix_rd_stb | output | 1 | Write-pixel counter read strobe |
| cpix_rd_stb | output | 1 | Copy-read-pixel counter read strobe |
| ctl_wr_stb | output | 1 | Status write strobe |
| geo_reset | output | 1 | Geometry section reset |

## Verification
The stall fault is the hardest state to reach from the ports. It needs an unbroken run of FAULT_LIMIT status reads that all see almost-full, and any other read in between zeroes the count. The bench builds the block with a small limit. It breaks the run once with a non-almost-full read, to show the count restarts, then finishes a full run and checks that the fault sets exactly on the final read and clears on command. Overflow is reached by holding `fifo_full` through a commit write.

// File: rtl/geo_io_pkg.sv
// Shared status-bit positions for the geometry I/O bridge.
package geo_io_pkg;
    localparam int ST_AFULL = 0;
    localparam int ST_SYNC  = 1;
    localparam int ST_OVF   = 5;
    localparam int ST_FAULT = 6;
    localparam int ST_RESET = 7;
endpackage

// File: rtl/geo_byte_port.sv
// One write-only byte port: a data register plus a single-cycle strobe.
// Assumes io_wr is a one-cycle qualifier registered upstream.
module geo_byte_port #(
    parameter int         DW      = 8,
    parameter logic [7:0] PORT_ID = 8'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_wr,
    input  logic [7:0]    io_addr,
    input  logic [DW-1:0] io_wdata,
    output logic          hit,
    output logic [DW-1:0] data,
    output logic          stb
);
    assign hit = io_wr && (io_addr == PORT_ID);

    // Load data and pulse the strobe; if/else keeps set and clear exclusive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            stb  <= 1'b0;
        end else if (hit) begin
            data <= io_wdata;
            stb  <= 1'b1;
        end else begin
            stb  <= 1'b0;
        end
    end

    // R2
    strobe_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> $past(io_wr && io_addr == PORT_ID));
endmodule

// File: rtl/geo_cmd_commit.sv
// Builds the 16-bit command on the commit byte and pushes it unless the FIFO
// is full, in which case a sticky overflow flag is set instead.
module geo_cmd_commit #(
    parameter bit COMMIT_HI = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo_hit,
    input  logic        hi_hit,
    input  logic [7:0]  io_wdata,
    input  logic [7:0]  lo_q,
    input  logic [7:0]  hi_q,
    input  logic        fifo_full,
    input  logic        ovf_clr,
    output logic [15:0] cmd_word,
    output logic        cmd_push,
    output logic        ovf
);
    logic        commit;
    logic [15:0] word_next;

    generate
        if (COMMIT_HI) begin : g_hi
            assign commit    = hi_hit;
            assign word_next = {io_wdata, lo_q};
        end else begin : g_lo
            assign commit    = lo_hit;
            assign word_next = {hi_q, io_wdata};
        end
    endgenerate

    // Push the word on a commit write, or flag overflow if the FIFO is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word <= '0;
            cmd_push <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            cmd_push <= commit && !fifo_full;
            if (commit && !fifo_full) cmd_word <= word_next;
            if (commit && fifo_full)  ovf <= 1'b1;
            else if (ovf_clr)         ovf <= 1'b0;
        end
    end

    // R4
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push |-> !$past(fifo_full));
    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(ovf_clr));
endmodule

// File: rtl/geo_stall_watch.sv
// Counts consecutive status reads that find the FIFO almost full and sets a
// sticky fault when the count reaches FAULT_LIMIT.
module geo_stall_watch #(
    parameter int FAULT_LIMIT = 65535
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic afull,
    input  logic clr,
    output logic fault
);
    localparam int CW = $clog2(FAULT_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(FAULT_LIMIT);

    logic [CW-1:0] cnt;

    // Saturating run counter with clear priority over a simultaneous read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            fault <= 1'b0;
        end else if (clr) begin
            cnt   <= '0;
            fault <= 1'b0;
        end else if (stat_rd) begin
            if (!afull)          cnt <= '0;
            else if (cnt != LIM) cnt <= cnt + 1'b1;
            if (afull && cnt == LIM - 1'b1) fault <= 1'b1;
        end
    end

    // R8
    fault_needs_afull_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(stat_rd && afull));
    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(clr));
endmodule

// File: rtl/geo_io_bridge.sv
// I/O bridge between an 8-bit CPU port bus and the geometry engine.
// Decodes the two command byte ports, the status/control port and the two
// collision counter ports. Assumes io_wr/io_rd are one-cycle qualifiers and
// io_addr is the low byte of the captured address.
module geo_io_bridge
    import geo_io_pkg::*;
#(
    parameter logic [7:0] PORT_LO     = 8'hF0,
    parameter logic [7:0] PORT_HI     = 8'hF1,
    parameter logic [7:0] PORT_STAT   = 8'hF2,
    parameter logic [7:0] PORT_WPIX   = 8'hF3,
    parameter logic [7:0] PORT_CPIX   = 8'hF4,
    parameter bit         COMMIT_HI   = 1'b1,
    parameter int         FAULT_LIMIT = 65535
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_addr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  rd_data,
    output logic [7:0]  geo_lo,
    output logic [7:0]  geo_hi,
    output logic        geo_lo_stb,
    output logic        geo_hi_stb,
    output logic [15:0] cmd_word,
    output logic        cmd_push,
    input  logic        fifo_full,
    input  logic        fifo_afull,
    input  logic        frame_sync,
    input  logic [7:0]  wpix_cnt,
    input  logic [7:0]  cpix_cnt,
    output logic        stat_rd_stb,
    output logic        wpix_rd_stb,
    output logic        cpix_rd_stb,
    output logic        ctl_wr_stb,
    output logic        geo_reset
);
    localparam int NPORT = 2;
    localparam logic [7:0] BYTE_IDS [NPORT] = '{PORT_LO, PORT_HI};

    logic [NPORT-1:0] b_hit, b_stb;
    logic [7:0]       b_data [NPORT];
    logic             ovf, fault;
    logic             ctl_hit, stat_hit, wpix_hit, cpix_hit;
    logic [7:0]       status;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_byte
            geo_byte_port #(.DW(8), .PORT_ID(BYTE_IDS[i])) u_port (
                .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
                .io_wdata(io_wdata), .hit(b_hit[i]), .data(b_data[i]),
                .stb(b_stb[i])
            );
        end
    endgenerate

    assign geo_lo     = b_data[0];
    assign geo_hi     = b_data[1];
    assign geo_lo_stb = b_stb[0];
    assign geo_hi_stb = b_stb[1];

    assign ctl_hit  = io_wr && (io_addr == PORT_STAT);
    assign stat_hit = io_rd && (io_addr == PORT_STAT);
    assign wpix_hit = io_rd && (io_addr == PORT_WPIX);
    assign cpix_hit = io_rd && (io_addr == PORT_CPIX);

    geo_cmd_commit #(.COMMIT_HI(COMMIT_HI)) u_commit (
        .clk(clk), .rst_n(rst_n), .lo_hit(b_hit[0]), .hi_hit(b_hit[1]),
        .io_wdata(io_wdata), .lo_q(b_data[0]), .hi_q(b_data[1]),
        .fifo_full(fifo_full), .ovf_clr(ctl_hit && io_wdata[ST_OVF]),
        .cmd_word(cmd_word), .cmd_push(cmd_push), .ovf(ovf)
    );

    geo_stall_watch #(.FAULT_LIMIT(FAULT_LIMIT)) u_watch (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_hit), .afull(fifo_afull),
        .clr(ctl_hit && io_wdata[ST_FAULT]), .fault(fault)
    );

    // Assemble the status byte from live inputs and sticky state.
    always_comb begin
        status            = '0;
        status[ST_AFULL]  = fifo_afull;
        status[ST_SYNC]   = frame_sync;
        status[ST_OVF]    = ovf;
        status[ST_FAULT]  = fault;
        status[ST_RESET]  = geo_reset;
    end

    // Register read data and the per-port read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data     <= '0;
            stat_rd_stb <= 1'b0;
            wpix_rd_stb <= 1'b0;
            cpix_rd_stb <= 1'b0;
        end else begin
            stat_rd_stb <= stat_hit;
            wpix_rd_stb <= wpix_hit;
            cpix_rd_stb <= cpix_hit;
            if (io_rd) begin
                if (stat_hit)      rd_data <= status;
                else if (wpix_hit) rd_data <= wpix_cnt;
                else if (cpix_hit) rd_data <= cpix_cnt;
                else               rd_data <= '0;
            end
        end
    end

    // Control write: reset bit and its strobe; the section starts asleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            geo_reset  <= 1'b1;
            ctl_wr_stb <= 1'b0;
        end else if (ctl_hit) begin
            geo_reset  <= io_wdata[ST_RESET];
            ctl_wr_stb <= 1'b1;
        end else begin
            ctl_wr_stb <= 1'b0;
        end
    end

    // R6
    rd_strobes_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_rd_stb, wpix_rd_stb, cpix_rd_stb}));
    // R7
    reset_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(geo_reset) |-> $past(io_wr && io_addr == PORT_STAT));
    // R3
    push_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push |-> (COMMIT_HI ? geo_hi_stb : geo_lo_stb));
endmodule

// File: tb/tb_geo_io_bridge.sv
module tb_geo_io_bridge;
    localparam int LIM = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_addr = '0, io_wdata = '0;
    logic        fifo_full = 1'b0, fifo_afull = 1'b0, frame_sync = 1'b0;
    logic [7:0]  wpix_cnt = 8'h00, cpix_cnt = 8'h00;
    logic [7:0]  rd_data, geo_lo, geo_hi;
    logic        geo_lo_stb, geo_hi_stb, cmd_push;
    logic [15:0] cmd_word;
    logic        stat_rd_stb, wpix_rd_stb, cpix_rd_stb, ctl_wr_stb, geo_reset;

    int checks = 0, errors = 0;
    bit model_on = 1'b0;

    // Reference model state
    int m_lo, m_hi, m_word, m_rd, m_cnt;
    bit m_lo_stb, m_hi_stb, m_push, m_srd, m_wrd, m_crd, m_cwr, m_rst, m_ovf, m_fault;

    always #4 clk = ~clk;

    geo_io_bridge #(.FAULT_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .rd_data(rd_data),
        .geo_lo(geo_lo), .geo_hi(geo_hi), .geo_lo_stb(geo_lo_stb),
        .geo_hi_stb(geo_hi_stb), .cmd_word(cmd_word), .cmd_push(cmd_push),
        .fifo_full(fifo_full), .fifo_afull(fifo_afull), .frame_sync(frame_sync),
        .wpix_cnt(wpix_cnt), .cpix_cnt(cpix_cnt), .stat_rd_stb(stat_rd_stb),
        .wpix_rd_stb(wpix_rd_stb), .cpix_rd_stb(cpix_rd_stb),
        .ctl_wr_stb(ctl_wr_stb), .geo_reset(geo_reset)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_lo = 0; m_hi = 0; m_word = 0; m_rd = 0; m_cnt = 0;
        m_lo_stb = 0; m_hi_stb = 0; m_push = 0; m_srd = 0; m_wrd = 0;
        m_crd = 0; m_cwr = 0; m_rst = 1; m_ovf = 0; m_fault = 0;
    endtask

    // Behavioural reference, advanced on each clock edge from the inputs.
    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            m_lo_stb = 0; m_hi_stb = 0; m_push = 0;
            m_srd = 0; m_wrd = 0; m_crd = 0; m_cwr = 0;
            if (io_rd) begin
                case (io_addr)
                    8'hF2: begin
                        m_rd = (m_rst << 7) | (m_fault << 6) | (m_ovf << 5)
                             | (frame_sync << 1) | fifo_afull;
                        m_srd = 1;
                        if (!fifo_afull) m_cnt = 0;
                        else begin
                            if (m_cnt == LIM - 1) m_fault = 1;
                            if (m_cnt < LIM) m_cnt++;
                        end
                    end
                    8'hF3: begin m_rd = wpix_cnt; m_wrd = 1; end
                    8'hF4: begin m_rd = cpix_cnt; m_crd = 1; end
                    default: m_rd = 0;
                endcase
            end
            if (io_wr) begin
                case (io_addr)
                    8'hF0: begin m_lo = io_wdata; m_lo_stb = 1; end
                    8'hF1: begin
                        m_hi = io_wdata; m_hi_stb = 1;
                        if (fifo_full) m_ovf = 1;
                        else begin m_push = 1; m_word = (io_wdata << 8) | m_lo; end
                    end
                    8'hF2: begin
                        m_cwr = 1; m_rst = io_wdata[7];
                        if (io_wdata[6]) begin m_fault = 0; m_cnt = 0; end
                        if (io_wdata[5]) m_ovf = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (model_on) begin
            chk("R1 geo_lo", geo_lo, m_lo);
            chk("R1 geo_hi", geo_hi, m_hi);
            chk("R2 geo_lo_stb", geo_lo_stb, m_lo_stb);
            chk("R2 geo_hi_stb", geo_hi_stb, m_hi_stb);
            chk("R3 cmd_push", cmd_push, m_push);
            if (m_push) chk("R3 cmd_word", cmd_word, m_word);
            chk("R5 R6 rd_data", rd_data, m_rd);
            chk("R6 stat_rd_stb", stat_rd_stb, m_srd);
            chk("R6 wpix_rd_stb", wpix_rd_stb, m_wrd);
            chk("R6 cpix_rd_stb", cpix_rd_stb, m_crd);
            chk("R7 ctl_wr_stb", ctl_wr_stb, m_cwr);
            chk("R7 geo_reset", geo_reset, m_rst);
        end
    end

    task automatic io_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr = 0;
        @(negedge clk);
    endtask

    task automatic io_read(logic [7:0] a);
        @(negedge clk); io_rd = 1; io_addr = a;
        @(negedge clk); io_rd = 0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        chk("R9 geo_reset", geo_reset, 1);
        chk("R9 geo_lo", geo_lo, 0);
        chk("R9 cmd_push", cmd_push, 0);
        chk("R9 rd_data", rd_data, 0);
        chk("R9 strobes", {geo_lo_stb, geo_hi_stb, stat_rd_stb, ctl_wr_stb}, 0);
        rst_n = 1; model_on = 1;
        @(negedge clk);

        // R1 R3: low then high commits a word
        io_write(8'hF0, 8'hAB);
        io_write(8'hF1, 8'hCD);
        // R2: only low writes, no push
        io_write(8'hF0, 8'h11);
        io_write(8'hF0, 8'h22);
        io_write(8'hF1, 8'h33);
        // R2: back-to-back writes and an unmapped write
        @(negedge clk); io_wr = 1; io_addr = 8'hF1; io_wdata = 8'h5A;
        @(negedge clk); io_addr = 8'hF1; io_wdata = 8'h5B;
        @(negedge clk); io_wr = 0;
        io_write(8'h55, 8'hFF);
        // R6: counters and unmapped read
        wpix_cnt = 8'h3C; cpix_cnt = 8'hC3;
        io_read(8'hF3);
        io_read(8'hF4);
        io_read(8'h77);
        // R5: status pattern variations
        frame_sync = 1; io_read(8'hF2);
        fifo_afull = 1; frame_sync = 0; io_read(8'hF2);
        fifo_afull = 0;
        // R7: release and reassert reset
        io_write(8'hF2, 8'h00);
        io_read(8'hF2);
        io_write(8'hF2, 8'h80);
        io_write(8'hF2, 8'h00);
        // R4: overflow when full
        fifo_full = 1;
        io_write(8'hF1, 8'h99);
        fifo_full = 0;
        io_read(8'hF2);
        io_write(8'hF0, 8'h01);
        io_write(8'hF1, 8'h02);
        io_read(8'hF2);
        io_write(8'hF2, 8'h20);
        io_read(8'hF2);
        // R8: interrupted run, then a full run to fault
        io_write(8'hF2, 8'h40);
        fifo_afull = 1;
        for (int i = 0; i < 5; i++) io_read(8'hF2);
        fifo_afull = 0; io_read(8'hF2);
        fifo_afull = 1;
        for (int i = 0; i < LIM - 1; i++) io_read(8'hF2);
        fifo_afull = 0; io_read(8'hF2);
        chk("R8 no fault after broken run", rd_data[6], 0);
        fifo_afull = 1;
        for (int i = 0; i < LIM; i++) io_read(8'hF2);
        io_read(8'hF2);
        chk("R8 fault set after full run", rd_data[6], 1);
        for (int i = 0; i < 3; i++) io_read(8'hF2);
        fifo_afull = 0;
        io_write(8'hF2, 8'h40);
        io_read(8'hF2);
        chk("R8 fault cleared", rd_data[6], 0);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule